// File: doc/BRIEF.md
# Flash Controller Sticky Status Register

This block is the 32-bit read-only status word of an embedded flash controller. The controller core reports what happens as one-cycle event pulses and a busy level. These cover command errors, accesses to locked regions, write-protection violations, verify failures, suspend and resume, and single or multiple ECC errors. The ECC errors are reported separately for the low and high 64-bit halves of the data path and of the lock-bit storage. The block catches each event in a flag that stays set until that flag's own clear condition occurs.

The clear rules differ from flag to flag:

- Some flags clear when software reads the word.
- The lock error also clears on a write to the command register.
- The verify-failure flag clears only when a new programming operation starts.
- The suspend flag clears on resume.
- The ready flag follows the busy level directly.

The word is always visible on `statusWord`. A read strobe marks the cycle in which software takes it. An interrupt is raised while the ready flag is set and the ready-interrupt enable is high. Every event is shown in the word from the clock edge that ends the event's cycle.

Top module: `flash_status_top`

## Requirements
- R1: After reset the word reads 0x00000001 and `irqOut` follows R3.
- R2: Bit 0 (ready) reads 0 in the cycle after any cycle with `busyIn` high, and reads 1 in the cycle after a cycle with `busyIn` low.
- R3: `irqOut` is 1 in exactly the cycles where bit 0 is 1 and `rdyIrqEn` is 1.
- R4: Bit 1 (command error) is set by `cmdErrEvt` and cleared by `rdStrobe`.
- R5: Bit 2 (lock error) is set by `lockErrEvt` and cleared by either `rdStrobe` or `cmdWrStrobe`.
- R6: Bit 3 (verify error) is set by `verifyFailEvt` and cleared only by `progStartEvt`. Reads and command writes leave it unchanged.
- R7: Bit 4 (write-protect error) is set by `wprotErrEvt` and cleared by `rdStrobe`.
- R8: Bit 5 (suspended) is set by `suspendEvt` and cleared only by `resumeEvt`. Reads leave it unchanged.
- R9: Data-path ECC flags are sticky and clear on `rdStrobe`. Bit 16 holds a single error in the low half (`dataEccSgl[0]`). Bit 17 holds a multiple error in the low half (`dataEccMul[0]`). Bit 18 holds a single error in the high half (`dataEccSgl[1]`). Bit 19 holds a multiple error in the high half (`dataEccMul[1]`).
- R10: Bits 20 to 23 hold the same four flags for the lock-bit storage, in the same order, driven by `lockEccSgl` and `lockEccMul`. They are sticky and clear on `rdStrobe`.
- R11: Bits 6 to 15 and 24 to 31 always read 0.
- R12: If a flag's set event and its clear condition fall in the same cycle, the flag is 1 afterwards. The word seen during a read cycle is the value from before that read's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | Status word is read this cycle |
| cmdWrStrobe | input | 1 | Command register is written this cycle |
| busyIn | input | 1 | Controller core is busy |
| cmdErrEvt | input | 1 | Invalid command or wrong key pulse |
| lockErrEvt | input | 1 | Program/erase of a locked region pulse |
| verifyFailEvt | input | 1 | Erase/write verify failure pulse |
| wprotErrEvt | input | 1 | Write-protection violation pulse |
| progStartEvt | input | 1 | Programming operation starts pulse |
| suspendEvt | input | 1 | Current command suspended pulse |
| resumeEvt | input | 1 | Programming resumed pulse |
| dataEccSgl | input | 2 | Corrected single ECC error, data path halves [0]=low, [1]=high |
| dataEccMul | input | 2 | Uncorrected multiple ECC error, data path halves |
| lockEccSgl | input | 2 | Corrected single ECC error, lock-bit halves |
| lockEccMul | input | 2 | Uncorrected multiple ECC error, lock-bit halves |
| rdyIrqEn | input | 1 | Ready interrupt enable |
| statusWord | output | 32 | Status word |
| irqOut | output | 1 | Ready interrupt |

## Verification
A wrong internal state shows up in `statusWord` one clock after the event or clear that caused it. There are no hidden stages, so it appears at the port within a single cycle. A clear rule wired to the wrong strobe leaves a flag at the wrong value after the first read, command write or programming start that should not have touched it. A swapped ECC lane shows up as a set bit in the wrong position. The bench compares the full word and the interrupt against its reference on every clock. It mixes directed collisions of set and clear events with a long random phase, so any stale or lost flag is seen within one cycle of diverging.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  // Clear strobes produced by the control and consumed by the datapath.
  typedef struct packed {
    logic clrReadable;  // flags cleared by a status read
    logic clrLock;      // lock error: status read or command write
    logic clrVerify;    // verify error: programming start
    logic clrSuspend;   // suspended: resume
  } clr_strobes_t;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ECC_PARTS = 2;

  // Bit positions decoded by software.
  localparam int unsigned BIT_READY   = 0;
  localparam int unsigned BIT_CMDERR  = 1;
  localparam int unsigned BIT_LOCKERR = 2;
  localparam int unsigned BIT_VERIFY  = 3;
  localparam int unsigned BIT_WPROT   = 4;
  localparam int unsigned BIT_SUSP    = 5;
  localparam int unsigned DATA_ECC_BASE = 16;
  localparam int unsigned LOCK_ECC_BASE = DATA_ECC_BASE + 2 * ECC_PARTS;

endpackage

// File: rtl/flash_status_sticky.sv
// One sticky flag: a set event always wins over a same-cycle clear.
module flash_status_sticky #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic setEvt,
  input  logic clrEvt,
  output logic flagQ
);

  always_ff @(posedge clk) begin
    if (!rstN)       flagQ <= RESET_VAL;
    else if (setEvt) flagQ <= 1'b1;
    else if (clrEvt) flagQ <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    setEvt |=> flagQ) else $error("set event lost"); // R12

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (clrEvt && !setEvt) |=> !flagQ) else $error("clear ignored"); // R4

  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!clrEvt && !setEvt) |=> $stable(flagQ)) else $error("flag drifted"); // R9

endmodule

// File: rtl/flash_status_ctrl.sv
// Turns bus and core strobes into per-rule clear strobes.
module flash_status_ctrl
  import flash_status_pkg::*;
(
  input  logic         rdStrobe,
  input  logic         cmdWrStrobe,
  input  logic         progStartEvt,
  input  logic         resumeEvt,
  output clr_strobes_t clrStrb
);

  always_comb begin
    clrStrb.clrReadable = rdStrobe;
    clrStrb.clrLock     = rdStrobe | cmdWrStrobe;
    clrStrb.clrVerify   = progStartEvt;
    clrStrb.clrSuspend  = resumeEvt;
  end

endmodule

// File: rtl/flash_status_dp.sv
// Flag storage and word assembly.
module flash_status_dp
  import flash_status_pkg::*;
#(
  parameter int unsigned PARTS = ECC_PARTS
) (
  input  logic               clk,
  input  logic               rstN,
  input  clr_strobes_t       clrStrb,
  input  logic               busyIn,
  input  logic               cmdErrEvt,
  input  logic               lockErrEvt,
  input  logic               verifyFailEvt,
  input  logic               wprotErrEvt,
  input  logic               suspendEvt,
  input  logic [PARTS-1:0]   dataEccSgl,
  input  logic [PARTS-1:0]   dataEccMul,
  input  logic [PARTS-1:0]   lockEccSgl,
  input  logic [PARTS-1:0]   lockEccMul,
  output logic [WORD_W-1:0]  wordQ
);

  localparam int unsigned LOCK_BASE = DATA_ECC_BASE + 2 * PARTS;

  logic readyQ;
  logic cmdErrQ, lockErrQ, verifyQ, wprotQ, suspQ;
  logic [PARTS-1:0] dSglQ, dMulQ, lSglQ, lMulQ;

  // Ready follows the busy level with one register stage.
  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b1;
    else       readyQ <= ~busyIn;
  end

  flash_status_sticky u_cmdErr (.clk(clk), .rstN(rstN), .setEvt(cmdErrEvt),
    .clrEvt(clrStrb.clrReadable), .flagQ(cmdErrQ));
  flash_status_sticky u_lockErr (.clk(clk), .rstN(rstN), .setEvt(lockErrEvt),
    .clrEvt(clrStrb.clrLock), .flagQ(lockErrQ));
  flash_status_sticky u_verify (.clk(clk), .rstN(rstN), .setEvt(verifyFailEvt),
    .clrEvt(clrStrb.clrVerify), .flagQ(verifyQ));
  flash_status_sticky u_wprot (.clk(clk), .rstN(rstN), .setEvt(wprotErrEvt),
    .clrEvt(clrStrb.clrReadable), .flagQ(wprotQ));
  flash_status_sticky u_susp (.clk(clk), .rstN(rstN), .setEvt(suspendEvt),
    .clrEvt(clrStrb.clrSuspend), .flagQ(suspQ));

  for (genvar h = 0; h < PARTS; h++) begin : g_ecc
    flash_status_sticky u_dSgl (.clk(clk), .rstN(rstN), .setEvt(dataEccSgl[h]),
      .clrEvt(clrStrb.clrReadable), .flagQ(dSglQ[h]));
    flash_status_sticky u_dMul (.clk(clk), .rstN(rstN), .setEvt(dataEccMul[h]),
      .clrEvt(clrStrb.clrReadable), .flagQ(dMulQ[h]));
    flash_status_sticky u_lSgl (.clk(clk), .rstN(rstN), .setEvt(lockEccSgl[h]),
      .clrEvt(clrStrb.clrReadable), .flagQ(lSglQ[h]));
    flash_status_sticky u_lMul (.clk(clk), .rstN(rstN), .setEvt(lockEccMul[h]),
      .clrEvt(clrStrb.clrReadable), .flagQ(lMulQ[h]));
  end

  always_comb begin
    wordQ = '0;
    wordQ[BIT_READY]   = readyQ;
    wordQ[BIT_CMDERR]  = cmdErrQ;
    wordQ[BIT_LOCKERR] = lockErrQ;
    wordQ[BIT_VERIFY]  = verifyQ;
    wordQ[BIT_WPROT]   = wprotQ;
    wordQ[BIT_SUSP]    = suspQ;
    for (int h = 0; h < int'(PARTS); h++) begin
      wordQ[DATA_ECC_BASE + 2*h]     = dSglQ[h];
      wordQ[DATA_ECC_BASE + 2*h + 1] = dMulQ[h];
      wordQ[LOCK_BASE + 2*h]         = lSglQ[h];
      wordQ[LOCK_BASE + 2*h + 1]     = lMulQ[h];
    end
  end

  AST_BUSY_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> !wordQ[BIT_READY]) else $error("ready while busy"); // R2

  AST_IDLE_RAISES_READY: assert property (@(posedge clk) disable iff (!rstN)
    !busyIn |=> wordQ[BIT_READY]) else $error("ready missing"); // R2

  AST_VERIFY_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rstN)
    (wordQ[BIT_VERIFY] && !clrStrb.clrVerify) |=> wordQ[BIT_VERIFY])
    else $error("verify flag lost"); // R6

  AST_SUSP_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rstN)
    (wordQ[BIT_SUSP] && !clrStrb.clrSuspend) |=> wordQ[BIT_SUSP])
    else $error("suspend flag lost"); // R8

  AST_LOCK_CLR_ON_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (clrStrb.clrLock && !lockErrEvt) |=> !wordQ[BIT_LOCKERR])
    else $error("lock flag not cleared"); // R5

endmodule

// File: rtl/flash_status_top.sv
module flash_status_top
  import flash_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdStrobe,
  input  logic        cmdWrStrobe,
  input  logic        busyIn,
  input  logic        cmdErrEvt,
  input  logic        lockErrEvt,
  input  logic        verifyFailEvt,
  input  logic        wprotErrEvt,
  input  logic        progStartEvt,
  input  logic        suspendEvt,
  input  logic        resumeEvt,
  input  logic [1:0]  dataEccSgl,
  input  logic [1:0]  dataEccMul,
  input  logic [1:0]  lockEccSgl,
  input  logic [1:0]  lockEccMul,
  input  logic        rdyIrqEn,
  output logic [31:0] statusWord,
  output logic        irqOut
);

  clr_strobes_t clrStrb;

  flash_status_ctrl u_ctrl (
    .rdStrobe(rdStrobe), .cmdWrStrobe(cmdWrStrobe),
    .progStartEvt(progStartEvt), .resumeEvt(resumeEvt), .clrStrb(clrStrb));

  flash_status_dp #(.PARTS(ECC_PARTS)) u_dp (
    .clk(clk), .rstN(rstN), .clrStrb(clrStrb), .busyIn(busyIn),
    .cmdErrEvt(cmdErrEvt), .lockErrEvt(lockErrEvt), .verifyFailEvt(verifyFailEvt),
    .wprotErrEvt(wprotErrEvt), .suspendEvt(suspendEvt),
    .dataEccSgl(dataEccSgl), .dataEccMul(dataEccMul),
    .lockEccSgl(lockEccSgl), .lockEccMul(lockEccMul), .wordQ(statusWord));

  assign irqOut = statusWord[BIT_READY] & rdyIrqEn;

  AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusWord[0] && rdyIrqEn)) else $error("stray irq"); // R3

  AST_WPROT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !wprotErrEvt) |=> !statusWord[4]) else $error("wp kept"); // R7

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[15:6] == '0) && (statusWord[31:24] == '0))
    else $error("reserved bit set"); // R11

endmodule

// File: tb/tb_flash_status_top.sv
module tb_flash_status_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdStrobe = 0, cmdWrStrobe = 0, busyIn = 0;
  logic cmdErrEvt = 0, lockErrEvt = 0, verifyFailEvt = 0, wprotErrEvt = 0;
  logic progStartEvt = 0, suspendEvt = 0, resumeEvt = 0, rdyIrqEn = 0;
  logic [1:0] dataEccSgl = 0, dataEccMul = 0, lockEccSgl = 0, lockEccMul = 0;
  logic [31:0] statusWord;
  logic irqOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [31:0] model = 32'h1;

  always #2.5 clk = ~clk;

  flash_status_top dut (.*);

  function automatic string tagOf(int b);
    if (b == 0) return "R2";
    if (b == 1) return "R4";
    if (b == 2) return "R5";
    if (b == 3) return "R6";
    if (b == 4) return "R7";
    if (b == 5) return "R8";
    if (b >= 16 && b <= 19) return "R9";
    if (b >= 20 && b <= 23) return "R10";
    return "R11";
  endfunction

  // Compare every output against the model; called away from the clock edge.
  task automatic compareAll(string ctx);
    bit bad = 0;
    compared++;
    for (int b = 0; b < 32; b++)
      if (statusWord[b] !== model[b]) begin
        $display("FAIL %s bit %0d (%s): actual %b expected %b", tagOf(b), b, ctx,
                 statusWord[b], model[b]);
        bad = 1;
      end
    if (irqOut !== (model[0] & rdyIrqEn)) begin
      $display("FAIL R3 irq (%s): actual %b expected %b", ctx, irqOut, model[0] & rdyIrqEn);
      bad = 1;
    end
    if (bad) mismatched++;
  endtask

  task automatic checkBit(int b, bit exp, string tag);
    compared++;
    if (statusWord[b] !== exp) begin
      mismatched++;
      $display("FAIL %s directed bit %0d: actual %b expected %b", tag, b, statusWord[b], exp);
    end
  endtask

  // Reference: each flag's rule written from the requirements.
  always @(posedge clk) begin
    if (!rstN) model = 32'h1;
    else begin
      model[0] = !busyIn;
      model[1] = cmdErrEvt     ? 1'b1 : (rdStrobe ? 1'b0 : model[1]);
      model[2] = lockErrEvt    ? 1'b1 : ((rdStrobe || cmdWrStrobe) ? 1'b0 : model[2]);
      model[3] = verifyFailEvt ? 1'b1 : (progStartEvt ? 1'b0 : model[3]);
      model[4] = wprotErrEvt   ? 1'b1 : (rdStrobe ? 1'b0 : model[4]);
      model[5] = suspendEvt    ? 1'b1 : (resumeEvt ? 1'b0 : model[5]);
      for (int h = 0; h < 2; h++) begin
        model[16+2*h] = dataEccSgl[h] ? 1'b1 : (rdStrobe ? 1'b0 : model[16+2*h]);
        model[17+2*h] = dataEccMul[h] ? 1'b1 : (rdStrobe ? 1'b0 : model[17+2*h]);
        model[20+2*h] = lockEccSgl[h] ? 1'b1 : (rdStrobe ? 1'b0 : model[20+2*h]);
        model[21+2*h] = lockEccMul[h] ? 1'b1 : (rdStrobe ? 1'b0 : model[21+2*h]);
      end
    end
  end

  task automatic idleInputs();
    rdStrobe = 0; cmdWrStrobe = 0; cmdErrEvt = 0; lockErrEvt = 0;
    verifyFailEvt = 0; wprotErrEvt = 0; progStartEvt = 0; suspendEvt = 0;
    resumeEvt = 0; dataEccSgl = 0; dataEccMul = 0; lockEccSgl = 0; lockEccMul = 0;
  endtask

  // Advance one cycle and compare at the following falling edge.
  task automatic tick(string ctx);
    @(posedge clk);
    @(negedge clk);
    compareAll(ctx);
    idleInputs();
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset value
    compareAll("R1 reset");
    checkBit(0, 1'b1, "R1");
    checkBit(1, 1'b0, "R1");
    rstN = 1;
    tick("R1 after release");

    // R2 / R3: busy and interrupt
    rdyIrqEn = 1; tick("R3 irq on");
    busyIn = 1; tick("R2 busy");
    busyIn = 0; tick("R2 idle");
    rdyIrqEn = 0; tick("R3 irq off");

    // R4/R7/R9/R10: set then read clears
    cmdErrEvt = 1; wprotErrEvt = 1; dataEccSgl = 2'b01; dataEccMul = 2'b10;
    lockEccSgl = 2'b10; lockEccMul = 2'b01; tick("set read-clear flags");
    checkBit(16, 1, "R9"); checkBit(19, 1, "R9"); checkBit(17, 0, "R9");
    checkBit(22, 1, "R10"); checkBit(21, 1, "R10"); checkBit(20, 0, "R10");
    rdStrobe = 1;
    checkBit(1, 1, "R12"); // read cycle shows pre-clear value
    tick("R4 read clears");
    checkBit(1, 0, "R4"); checkBit(4, 0, "R7");

    // R5: lock error cleared by command write
    lockErrEvt = 1; tick("R5 set");
    cmdWrStrobe = 1; tick("R5 cmd write clears");
    checkBit(2, 0, "R5");

    // R6: verify flag survives reads and command writes
    verifyFailEvt = 1; tick("R6 set");
    rdStrobe = 1; cmdWrStrobe = 1; tick("R6 read");
    checkBit(3, 1, "R6");
    progStartEvt = 1; tick("R6 prog start");
    checkBit(3, 0, "R6");

    // R8: suspend survives reads, clears on resume
    suspendEvt = 1; tick("R8 set");
    rdStrobe = 1; tick("R8 read");
    checkBit(5, 1, "R8");
    resumeEvt = 1; tick("R8 resume");
    checkBit(5, 0, "R8");

    // R12: set and clear in the same cycle
    cmdErrEvt = 1; rdStrobe = 1; lockErrEvt = 1; cmdWrStrobe = 1;
    verifyFailEvt = 1; progStartEvt = 1; dataEccMul = 2'b11; tick("R12 collision");
    checkBit(1, 1, "R12"); checkBit(2, 1, "R12"); checkBit(3, 1, "R12");
    checkBit(17, 1, "R12"); checkBit(19, 1, "R12");

    // Random phase, compared every cycle (R11 reserved bits included).
    for (int i = 0; i < 4000; i++) begin
      rdStrobe      = ($urandom % 5) == 0;
      cmdWrStrobe   = ($urandom % 7) == 0;
      busyIn        = ($urandom % 3) == 0;
      rdyIrqEn      = ($urandom % 2) == 0;
      cmdErrEvt     = ($urandom % 9) == 0;
      lockErrEvt    = ($urandom % 9) == 0;
      verifyFailEvt = ($urandom % 11) == 0;
      wprotErrEvt   = ($urandom % 9) == 0;
      progStartEvt  = ($urandom % 8) == 0;
      suspendEvt    = ($urandom % 10) == 0;
      resumeEvt     = ($urandom % 8) == 0;
      dataEccSgl    = 2'(($urandom % 6) == 0 ? $urandom : 0);
      dataEccMul    = 2'(($urandom % 6) == 0 ? $urandom : 0);
      lockEccSgl    = 2'(($urandom % 6) == 0 ? $urandom : 0);
      lockEccMul    = 2'(($urandom % 6) == 0 ? $urandom : 0);
      tick("random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule